// File: doc/BRIEF.md
# Write-Back Cache with Scratchpad Carve-Out

This block is a unified cache controller for instruction and data traffic, organised as four ways of sixteen-byte lines. Writes stay in the array until the line is replaced or flushed. Each line records which of its four 32-bit words were modified, so a replacement or flush writes only those words to memory. Memory traffic leaves through a single-word request/acknowledge port. A separate port lets DMA traffic probe the array: dirty data is pushed out first, and a DMA write drops the line.

A two-bit size control reserves part of the last way as scratchpad RAM. The scratchpad covers half, three quarters or all of that way's sets (2, 3 or 4 KB with default parameters). It is reached through an address window that starts at a programmable base. Scratchpad words are always valid. They never cause memory traffic and are left untouched by a flush. Caching can be refused in several ways: a global disable stops new fills but still serves resident lines, and per-access hints and a non-cacheable address range turn single accesses into plain memory operations.

Top module: `wbsc_cache`

## Requirements
- R1: A cacheable miss fills the whole line, which takes four memory reads. The access then completes from the array. Later reads and writes to that line cause no memory traffic, and a read returns the last value written.
- R2: A line keeps one dirty flag per 32-bit word. When a dirty line is evicted, exactly its modified words are written to memory.
- R3: An access inside the scratchpad window is served from the last way with no memory traffic. Scratchpad contents are never written to memory and survive a flush.
- R4: `sp_mode` sets the window size, measured from `sp_base`: 0 = none, 1 = the first half of the sets, 2 = the first three quarters, 3 = all sets. At 16 bytes per set this is 2, 3 and 4 KB with default parameters. Addresses past the window are ordinary memory.
- R5: While `cache_dis` is high, no line fill starts. Hits are still served from the array, and each miss becomes one single-word memory access.
- R6: A flush request writes back every dirty word and invalidates every non-scratchpad line. It then pulses `flush_ack`.
- R7: A snoop that hits a line with dirty words writes those words to memory before `snp_ack`. A snoop write invalidates a matching line.
- R8: A CPU write with `cpu_wt` high reaches memory before `cpu_ack`. On a hit the line is also updated. On a miss no line is allocated.
- R9: A CPU access with `cpu_ld` high, or with an address in [`nc_lo`, `nc_hi`), allocates no line. A miss becomes a single-word memory access.
- R10: `mem_req` stays high, with a stable address and direction, until `mem_ack`. Each acknowledge completes one word.
- R11: After reset, `cpu_ack`, `snp_ack`, `flush_ack` and `mem_req` are low, and no line is valid. At most one acknowledge pulses in any cycle.
- R12: The replacement victim is the lowest-numbered usable invalid way. If every usable way is valid, the victim is the way chosen by the tree pseudo-LRU bits. A scratchpad-reserved line is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_we | input | 1 | CPU write when high |
| cpu_addr | input | ADDR_W | CPU byte address (word aligned) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_wt | input | 1 | Write-through hint for this access |
| cpu_ld | input | 1 | Local no-allocate hint for this access |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cache_dis | input | 1 | Global disable of new fills |
| nc_lo | input | ADDR_W | Non-cacheable range start (inclusive) |
| nc_hi | input | ADDR_W | Non-cacheable range end (exclusive) |
| sp_mode | input | 2 | Scratchpad size select |
| sp_base | input | ADDR_W | Scratchpad window base address |
| flush_req | input | 1 | Write back and invalidate request |
| flush_ack | output | 1 | Flush completion pulse |
| snp_req | input | 1 | DMA snoop request, held until snp_ack |
| snp_we | input | 1 | Snoop is for a DMA write |
| snp_addr | input | ADDR_W | Snoop address |
| snp_ack | output | 1 | Snoop completion pulse |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory word acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bound properties check the memory handshake hold, the exclusivity of the three acknowledges, and that a CPU acknowledge always follows a request. They also check that no memory write ever targets the active scratchpad window and that no fill begins while the global disable is high. Other behaviour only shows in the bench's scenarios, measured by counting memory reads and writes around each access. These scenarios cover per-word write-back counts on eviction and flush, the pseudo-LRU victim, and scratchpad data surviving a flush. They also cover the window boundaries for each size, snoop write-back before acknowledge, and refetch after a snoop invalidation.

// File: rtl/wbsc_pkg.sv
package wbsc_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_RESP, S_WB, S_FILL, S_UNC, S_SNPF, S_FLUSH
   } st_t;

   // sets reserved for scratchpad per size code
   function automatic int unsigned sp_lines(input logic [1:0] mode, input int unsigned sets);
      case (mode)
         2'd1:    return sets / 2;
         2'd2:    return (sets * 3) / 4;
         2'd3:    return sets;
         default: return 0;
      endcase
   endfunction

   // tree bits point toward the next victim; touching a way points them away
   function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
      logic [2:0] n;
      n = t;
      n[0] = ~w[1];
      if (!w[1]) n[1] = ~w[0];
      else       n[2] = ~w[0];
      return n;
   endfunction

endpackage

// File: rtl/wbsc_victim.sv
module wbsc_victim #(
   parameter int WAYS = 4,
   localparam int WW = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] usable,
   input  logic [WAYS-1:0] valid,
   input  logic [WAYS-2:0] tree,
   output logic [WW-1:0]   way
);
   always_comb begin
      way = {tree[0], tree[0] ? tree[2] : tree[1]};
      if (!usable[way]) way = way ^ WW'(1);
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (usable[i] && !valid[i]) way = WW'(i);
      end
   end
endmodule

// File: rtl/wbsc_spwin.sv
module wbsc_spwin #(
   parameter int ADDR_W = 32,
   parameter int SETS   = 256,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [1:0]        mode,
   output logic              hit,
   output logic [SET_W-1:0]  idx,
   output logic [1:0]        word
);
   logic [ADDR_W-1:0] off, lim;
   always_comb begin
      off  = addr - base;
      lim  = ADDR_W'(wbsc_pkg::sp_lines(mode, SETS)) << 4;
      hit  = (addr >= base) && (off < lim);
      idx  = off[SET_W+3:4];
      word = off[3:2];
   end
endmodule

// File: rtl/wbsc_cache.sv
module wbsc_cache
   import wbsc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SETS   = 256,
   parameter int WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   input  logic              cpu_wt,
   input  logic              cpu_ld,
   output logic              cpu_ack,
   output logic [31:0]       cpu_rdata,
   input  logic              cache_dis,
   input  logic [ADDR_W-1:0] nc_lo,
   input  logic [ADDR_W-1:0] nc_hi,
   input  logic [1:0]        sp_mode,
   input  logic [ADDR_W-1:0] sp_base,
   input  logic              flush_req,
   output logic              flush_ack,
   input  logic              snp_req,
   input  logic              snp_we,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam int SET_W = $clog2(SETS);
   localparam int WW    = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - SET_W - 4;
   localparam int FL_W  = SET_W + WW;

   if (WAYS != 4) begin : g_bad_ways
      $error("wbsc_cache: tree replacement needs WAYS == 4");
   end
   if ((SETS < 4) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
      $error("wbsc_cache: SETS must be a power of two >= 4");
   end

   logic [TAG_W-1:0] tag_q [WAYS][SETS];
   logic [SETS-1:0]  vld_q [WAYS];
   logic [3:0]       drt_q [WAYS][SETS];
   logic [WAYS-2:0]  lru_q [SETS];
   logic [31:0]      dat_q [WAYS][SETS*4];

   st_t st, ret;
   logic [SET_W-1:0] wb_set;
   logic [WW-1:0]    wb_way;
   logic [1:0]       cnt;
   logic [TAG_W-1:0] fill_tag;
   logic [FL_W-1:0]  fl_idx;

   wire [SET_W-1:0] c_set  = cpu_addr[SET_W+3:4];
   wire [TAG_W-1:0] c_tag  = cpu_addr[ADDR_W-1:SET_W+4];
   wire [1:0]       c_word = cpu_addr[3:2];
   wire [SET_W-1:0] s_set  = snp_addr[SET_W+3:4];
   wire [TAG_W-1:0] s_tag  = snp_addr[ADDR_W-1:SET_W+4];
   wire [SET_W-1:0] fl_set = fl_idx[FL_W-1:WW];
   wire [WW-1:0]    fl_way = fl_idx[WW-1:0];
   wire [SET_W:0]   sp_n   = (SET_W+1)'(sp_lines(sp_mode, SETS));

   logic [WAYS-1:0] c_use, s_use, c_valid, c_hitv, s_hitv;
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign c_use[w]   = !((w == WAYS - 1) && ({1'b0, c_set} < sp_n));
      assign s_use[w]   = !((w == WAYS - 1) && ({1'b0, s_set} < sp_n));
      assign c_valid[w] = vld_q[w][c_set];
      assign c_hitv[w]  = vld_q[w][c_set] && (tag_q[w][c_set] == c_tag) && c_use[w];
      assign s_hitv[w]  = vld_q[w][s_set] && (tag_q[w][s_set] == s_tag) && s_use[w];
   end

   logic [WW-1:0] c_way, s_way, vic;
   always_comb begin
      c_way = '0;
      s_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (c_hitv[i]) c_way = WW'(i);
         if (s_hitv[i]) s_way = WW'(i);
      end
   end

   wbsc_victim #(.WAYS(WAYS)) u_vic (
      .usable(c_use), .valid(c_valid), .tree(lru_q[c_set]), .way(vic)
   );

   logic             sp_hit;
   logic [SET_W-1:0] sp_idx;
   logic [1:0]       sp_word;
   wbsc_spwin #(.ADDR_W(ADDR_W), .SETS(SETS)) u_sp (
      .addr(cpu_addr), .base(sp_base), .mode(sp_mode),
      .hit(sp_hit), .idx(sp_idx), .word(sp_word)
   );

   wire c_hit  = |c_hitv;
   wire s_hit  = |s_hitv;
   wire in_nc  = (cpu_addr >= nc_lo) && (cpu_addr < nc_hi);
   wire alloc  = !cache_dis && !cpu_ld && !in_nc && !(cpu_we && cpu_wt);
   wire fl_rs  = (fl_way == WW'(WAYS - 1)) && ({1'b0, fl_set} < sp_n);
   wire fl_v   = vld_q[fl_way][fl_set] && !fl_rs;
   wire fl_wb  = fl_v && (|drt_q[fl_way][fl_set]);
   wire fl_end = (fl_idx == {FL_W{1'b1}});

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {cpu_addr[ADDR_W-1:2], 2'b00};
      mem_wdata = cpu_wdata;
      case (st)
         S_WB: begin
            mem_req   = drt_q[wb_way][wb_set][cnt];
            mem_we    = 1'b1;
            mem_addr  = {tag_q[wb_way][wb_set], wb_set, cnt, 2'b00};
            mem_wdata = dat_q[wb_way][{wb_set, cnt}];
         end
         S_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {fill_tag, wb_set, cnt, 2'b00};
         end
         S_UNC: begin
            mem_req = 1'b1;
            mem_we  = cpu_we;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      cpu_ack   <= 1'b0;
      snp_ack   <= 1'b0;
      flush_ack <= 1'b0;
      if (!rst_n) begin
         st        <= S_IDLE;
         ret       <= S_IDLE;
         cnt       <= '0;
         fl_idx    <= '0;
         cpu_rdata <= '0;
         for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
         for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (flush_req) begin
                  fl_idx <= '0;
                  st     <= S_FLUSH;
               end else if (snp_req) begin
                  if (s_hit && (|drt_q[s_way][s_set])) begin
                     wb_set <= s_set; wb_way <= s_way; cnt <= '0;
                     ret    <= S_SNPF; st <= S_WB;
                  end else st <= S_SNPF;
               end else if (cpu_req) begin
                  if (sp_hit) begin
                     if (cpu_we) dat_q[WW'(WAYS-1)][{sp_idx, sp_word}] <= cpu_wdata;
                     else        cpu_rdata <= dat_q[WW'(WAYS-1)][{sp_idx, sp_word}];
                     cpu_ack <= 1'b1;
                     st      <= S_RESP;
                  end else if (c_hit) begin
                     lru_q[c_set] <= plru_touch(lru_q[c_set], c_way);
                     if (cpu_we) begin
                        dat_q[c_way][{c_set, c_word}] <= cpu_wdata;
                        if (cpu_wt) st <= S_UNC;
                        else begin
                           drt_q[c_way][c_set][c_word] <= 1'b1;
                           cpu_ack <= 1'b1;
                           st      <= S_RESP;
                        end
                     end else begin
                        cpu_rdata <= dat_q[c_way][{c_set, c_word}];
                        cpu_ack   <= 1'b1;
                        st        <= S_RESP;
                     end
                  end else if (alloc) begin
                     wb_set <= c_set; wb_way <= vic; fill_tag <= c_tag;
                     cnt    <= '0;    ret    <= S_FILL;
                     st <= (vld_q[vic][c_set] && (|drt_q[vic][c_set])) ? S_WB : S_FILL;
                  end else st <= S_UNC;
               end
            end
            S_WB: begin
               if (!drt_q[wb_way][wb_set][cnt] || mem_ack) begin
                  drt_q[wb_way][wb_set][cnt] <= 1'b0;
                  cnt <= cnt + 2'd1;
                  if (cnt == 2'd3) st <= ret;
               end
            end
            S_FILL: begin
               if (mem_ack) begin
                  dat_q[wb_way][{wb_set, cnt}] <= mem_rdata;
                  cnt <= cnt + 2'd1;
                  if (cnt == 2'd3) begin
                     tag_q[wb_way][wb_set]  <= fill_tag;
                     vld_q[wb_way][wb_set]  <= 1'b1;
                     drt_q[wb_way][wb_set]  <= '0;
                     st <= S_IDLE;
                  end
               end
            end
            S_UNC: begin
               if (mem_ack) begin
                  if (!cpu_we) cpu_rdata <= mem_rdata;
                  cpu_ack <= 1'b1;
                  st      <= S_RESP;
               end
            end
            S_SNPF: begin
               if (s_hit && snp_we) vld_q[s_way][s_set] <= 1'b0;
               snp_ack <= 1'b1;
               st      <= S_RESP;
            end
            S_FLUSH: begin
               if (fl_wb) begin
                  wb_set <= fl_set; wb_way <= fl_way; cnt <= '0;
                  ret    <= S_FLUSH; st <= S_WB;
               end else begin
                  if (fl_v) vld_q[fl_way][fl_set] <= 1'b0;
                  fl_idx <= fl_idx + 1'b1;
                  if (fl_end) begin
                     flush_ack <= 1'b1;
                     st        <= S_RESP;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wbsc_chk.sv
module wbsc_chk
   import wbsc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SETS   = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ack,
   input logic              snp_ack,
   input logic              flush_ack,
   input logic              cache_dis,
   input logic [1:0]        sp_mode,
   input logic [ADDR_W-1:0] sp_base,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input st_t               st
);
   logic [ADDR_W-1:0] win_len;
   logic              wr_in_win;
   always_comb begin
      win_len   = ADDR_W'(sp_lines(sp_mode, SETS) * 16);
      wr_in_win = (mem_addr >= sp_base) && ((mem_addr - sp_base) < win_len);
   end

   a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r3_sp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !wr_in_win);

   a_r5_no_fill_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == S_FILL) |-> !cache_dis);

   a_r11_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_ack, snp_ack, flush_ack}));

   a_r1_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> $past(cpu_req));
endmodule

bind wbsc_cache wbsc_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ack(cpu_ack),
   .snp_ack(snp_ack), .flush_ack(flush_ack), .cache_dis(cache_dis),
   .sp_mode(sp_mode), .sp_base(sp_base), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_ack(mem_ack), .st(st)
);

// File: tb/sim_wbsc_cache.sv
module sim_wbsc_cache;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_req = 0, cpu_we = 0, cpu_wt = 0, cpu_ld = 0;
   logic [31:0] cpu_addr = 0, cpu_wdata = 0;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        cache_dis = 0;
   logic [31:0] nc_lo = 32'h8000, nc_hi = 32'h9000;
   logic [1:0]  sp_mode = 0;
   logic [31:0] sp_base = 32'h4000_0000;
   logic        flush_req = 0, flush_ack;
   logic        snp_req = 0, snp_we = 0, snp_ack;
   logic [31:0] snp_addr = 0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 0;
   logic [31:0] mem_rdata = 0;

   wbsc_cache u0 (.*);

   always #10 clk = ~clk;

   typedef struct { logic [31:0] val; string tag; } exp_t;
   exp_t q[$];
   logic [31:0] mem  [logic [31:0]];
   logic [31:0] gold [logic [31:0]];
   int total = 0, bad = 0, rd_n = 0, wr_n = 0;
   bit cur_rd = 0;

   function automatic logic [31:0] dflt(input logic [31:0] a);
      return a ^ 32'h5A5A_0000;
   endfunction
   function automatic logic [31:0] mrd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : dflt(a);
   endfunction
   function automatic logic [31:0] grd(input logic [31:0] a);
      return gold.exists(a) ? gold[a] : dflt(a);
   endfunction

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", r, act, exp);
      end
   endtask

   // memory model: one word per acknowledge
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin mem[mem_addr] = mem_wdata; wr_n++; end
         else begin mem_rdata <= mrd(mem_addr); rd_n++; end
      end else mem_ack <= 1'b0;
   end

   // scoreboard monitor
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && cpu_ack && cur_rd) begin
         if (q.size() == 0) check("R1 unexpected read ack", 32'd1, 32'd0);
         else begin
            e = q.pop_front();
            check(e.tag, cpu_rdata, e.val);
         end
      end
   end

   task automatic cpu(input bit we, input logic [31:0] a, input logic [31:0] d,
                      input bit wt, input bit ld, input string r);
      exp_t e;
      if (!we) begin e.val = grd(a); e.tag = r; q.push_back(e); end
      else gold[a] = d;
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_wt = wt; cpu_ld = ld;
      cur_rd = !we;
      do @(negedge clk); while (!cpu_ack);
      cpu_req = 0; cpu_wt = 0; cpu_ld = 0;
   endtask

   task automatic rd(input logic [31:0] a, input string r);
      cpu(0, a, 0, 0, 0, r);
   endtask
   task automatic wr(input logic [31:0] a, input logic [31:0] d, input string r);
      cpu(1, a, d, 0, 0, r);
   endtask

   task automatic flush();
      @(negedge clk); flush_req = 1;
      do @(negedge clk); while (!flush_ack);
      flush_req = 0;
   endtask

   task automatic snoop(input bit we, input logic [31:0] a);
      @(negedge clk); snp_req = 1; snp_we = we; snp_addr = a;
      do @(negedge clk); while (!snp_ack);
      snp_req = 0; snp_we = 0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      finish_run();
   end

   initial begin
      int r0, w0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R11 reset cpu_ack", 32'(cpu_ack), 0);
      check("R11 reset mem_req", 32'(mem_req), 0);
      check("R11 reset snp/flush ack", 32'({snp_ack, flush_ack}), 0);

      // R1: allocate on write, then hits stay in the array
      r0 = rd_n; w0 = wr_n;
      wr(32'h1000, 32'h1111_1111, "R1 write");
      rd(32'h1000, "R1 read back");
      wr(32'h1008, 32'h2222_2222, "R1 write hit");
      rd(32'h1004, "R1 filled word");
      check("R1 one line fill", 32'(rd_n - r0), 4);
      check("R1 no write traffic", 32'(wr_n - w0), 0);

      // R2 / R12: fill ways 1..3, then evict way 0 holding two dirty words
      rd(32'h2000, "R12 fill"); rd(32'h3000, "R12 fill"); rd(32'h4000, "R12 fill");
      w0 = wr_n;
      rd(32'h5000, "R12 evicting read");
      check("R2 R12 dirty words only", 32'(wr_n - w0), 2);
      check("R2 word0 in memory", mrd(32'h1000), 32'h1111_1111);
      check("R2 word2 in memory", mrd(32'h1008), 32'h2222_2222);
      rd(32'h1008, "R2 refetch");

      // R8: write-through miss and hit
      w0 = wr_n; r0 = rd_n;
      cpu(1, 32'h6000, 32'h6666_0000, 1, 0, "R8 wt miss");
      check("R8 wt miss write", 32'(wr_n - w0), 1);
      check("R8 wt miss no fill", 32'(rd_n - r0), 0);
      rd(32'h6000, "R8 wt miss data");
      rd(32'h2010, "R8 fill set1");
      w0 = wr_n; r0 = rd_n;
      cpu(1, 32'h2010, 32'h7777_0000, 1, 0, "R8 wt hit");
      rd(32'h2010, "R8 wt hit data");
      check("R8 wt hit write", 32'(wr_n - w0), 1);
      check("R8 wt hit no read", 32'(rd_n - r0), 0);
      check("R8 memory updated", mrd(32'h2010), 32'h7777_0000);

      // R9: local no-allocate hint and non-cacheable range
      r0 = rd_n;
      cpu(0, 32'h7020, 0, 0, 1, "R9 ld read");
      cpu(0, 32'h7020, 0, 0, 1, "R9 ld read again");
      rd(32'h8030, "R9 nc read"); rd(32'h8030, "R9 nc read again");
      check("R9 single word reads", 32'(rd_n - r0), 4);
      w0 = wr_n;
      wr(32'h8040, 32'h8888_0000, "R9 nc write");
      check("R9 nc write direct", 32'(wr_n - w0), 1);

      // R5: global disable
      wr(32'h3050, 32'hDEAD_0001, "R5 dirty");
      wr(32'h3058, 32'hDEAD_0003, "R5 dirty");
      cache_dis = 1;
      r0 = rd_n;
      rd(32'h3050, "R5 hit while off");
      check("R5 hit no traffic", 32'(rd_n - r0), 0);
      rd(32'hA060, "R5 miss"); rd(32'hA060, "R5 miss again");
      check("R5 no fill", 32'(rd_n - r0), 2);

      // R6: flush writes back the two dirty words and invalidates
      w0 = wr_n;
      flush();
      check("R6 flush write-back", 32'(wr_n - w0), 2);
      r0 = rd_n;
      rd(32'h3050, "R6 after flush");
      check("R6 line invalid", 32'(rd_n - r0), 1);
      cache_dis = 0;

      // R3 / R4: scratchpad
      sp_mode = 2'd1;
      r0 = rd_n; w0 = wr_n;
      wr(32'h4000_0010, 32'hAAAA_0001, "R3 sp write");
      wr(32'h4000_07FC, 32'hBBBB_0002, "R4 sp last word 2KB");
      rd(32'h4000_0010, "R3 sp read");
      flush();
      rd(32'h4000_0010, "R3 sp after flush");
      rd(32'h4000_07FC, "R4 sp after flush");
      check("R3 sp no reads", 32'(rd_n - r0), 0);
      check("R3 sp no writes", 32'(wr_n - w0), 0);
      r0 = rd_n;
      rd(32'h4000_0800, "R4 beyond 2KB");
      check("R4 beyond window fills", 32'(rd_n - r0), 4);
      sp_mode = 2'd3;
      r0 = rd_n;
      wr(32'h4000_0800, 32'hCCCC_0003, "R4 sp 4KB");
      rd(32'h4000_0800, "R4 sp 4KB read");
      check("R4 4KB window no traffic", 32'(rd_n - r0), 0);
      sp_mode = 2'd2;
      r0 = rd_n;
      rd(32'h4000_0800, "R4 sp 3KB read");
      wr(32'h4000_0BF0, 32'hDDDD_0004, "R4 sp 3KB top");
      rd(32'h4000_0BF0, "R4 sp 3KB top read");
      check("R4 3KB inside no traffic", 32'(rd_n - r0), 0);
      rd(32'h4000_0C00, "R4 beyond 3KB");
      check("R4 beyond 3KB fills", 32'(rd_n - r0), 4);

      // R7: snoops
      wr(32'hB0A0, 32'h1234_5678, "R7 dirty");
      w0 = wr_n;
      snoop(0, 32'hB0A0);
      check("R7 snoop write-back", 32'(wr_n - w0), 1);
      check("R7 memory coherent", mrd(32'hB0A0), 32'h1234_5678);
      snoop(0, 32'hB0A0);
      check("R7 clean snoop", 32'(wr_n - w0), 1);
      snoop(1, 32'hB0A0);
      mem[32'hB0A0] = 32'h5555_AAAA;
      gold[32'hB0A0] = 32'h5555_AAAA;
      r0 = rd_n;
      rd(32'hB0A0, "R7 after DMA write");
      check("R7 line invalidated", 32'(rd_n - r0), 4);

      repeat (2) @(negedge clk);
      check("R1 scoreboard drained", 32'(q.size()), 0);
      finish_run();
   end
endmodule